// File: doc/BRIEF.md
# Lock-Aware LRU Victim Selector

This block tracks a full recency ranking of the four ways in each set of a four-way set-associative cache. When the cache misses, it names the way to refill. The ranking is held per set as four 2-bit way numbers, from most recent to least recent. The block also holds a lock bit for every line. A hit moves the hit way to the front of the ranking. A miss refill moves the chosen victim to the front. Each way that was ahead of the moved way slips back one place.

Victim selection works as follows. An access flagged as streaming always goes to way 0. Otherwise the block walks the ranking from the least recent entry toward the front. It takes the first way that is either invalid or unlocked. If the three rear entries are all valid and locked, the front (most recent) way is used. Lock requests for single lines come in through a small request port. A lock that would leave every way of a set locked is refused, so each set always keeps at least one replaceable line. The caller supplies the set index and the per-way valid bits of the addressed set. The victim is a combinational function of those inputs and the stored state. All updates take effect on the next rising clock edge.

Top module: `lru_victim_sel`

## Requirements
- R1: After reset, every set ranks its ways as way 0 most recent, then way 1, then way 2, then way 3 least recent, and every lock bit is clear. With all ways valid and no streaming, `victim_way` is therefore 3 in every set.
- R2: When `stream` is 1, `victim_way` is 0, whatever the ranking, valid bits and lock bits are.
- R3: When `stream` is 0, the block examines the least recent way first, then the second least recent, then the second most recent. `victim_way` is the first of these that is invalid (`way_valid` bit 0) or unlocked.
- R4: When `stream` is 0 and the three rear ways are all valid and locked, `victim_way` is the most recent way.
- R5: A cycle with `hit` = 1 makes `hit_way` the most recent way of the addressed set. The ways ranked ahead of it each move back one place. The ways behind it keep their places.
- R6: A cycle with `miss` = 1 and `hit` = 0 moves the way shown on `victim_way` in that cycle to the front, in the same way as R5.
- R7: When `hit` and `miss` are both 1, only the hit update of R5 is performed.
- R8: A lock request (`lock_req` = 1, `unlock_req` = 0) for `lock_way` is accepted, and `lock_ok` is 1 in that cycle, unless setting that lock bit would make all four lock bits of the set 1. A refused request leaves the lock bits unchanged, and `lock_ok` is 0.
- R9: An unlock request (`unlock_req` = 1) clears the lock bit of `lock_way` in the addressed set and is always accepted, with `lock_ok` = 1. It takes priority over a lock request in the same cycle, and that lock request is then dropped.
- R10: Updates change only the set named by `set_idx`. All other sets keep their ranking and lock bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| set_idx | input | 7 | Set addressed this cycle |
| hit | input | 1 | Access hit in the addressed set |
| hit_way | input | 2 | Way that hit |
| miss | input | 1 | Access missed; the victim is refilled this cycle |
| stream | input | 1 | Access is marked streaming |
| way_valid | input | 4 | Valid bit of each way of the addressed set, bit n for way n |
| lock_req | input | 1 | Request to lock line `lock_way` |
| unlock_req | input | 1 | Request to unlock line `lock_way` |
| lock_way | input | 2 | Way that a lock or unlock request targets |
| victim_way | output | 2 | Way chosen for replacement (combinational) |
| lock_ok | output | 1 | The lock or unlock request of this cycle is accepted (combinational) |

## Verification
Right after reset, every set is swept with all ways valid and no streaming, which confirms the reset ranking (R1) in each set separately. Directed sequences separate the different update paths:
- Hits on rear ways show that ways ahead of the hit way shift back while ways behind it stay put.
- A hit and a miss in the same cycle, on different ways, show which of the two was applied.
- Locking three ways and then driving the unlocked way to the front forces the front-way fallback (R4).
- A locked but invalid way at the rear shows that invalid lines stay selectable.

A long pseudo-random run then mixes hits, misses, streaming accesses, valid patterns, and lock and unlock requests over a few sets. A model in the bench computes the expected ranking independently.

// File: rtl/lru_pkg.sv
package lru_pkg;
  localparam int NUM_WAYS = 4;
  localparam int WAY_W    = $clog2(NUM_WAYS);

  typedef logic [WAY_W-1:0] way_t;
  // rank 0 = most recent, rank NUM_WAYS-1 = least recent
  typedef way_t [NUM_WAYS-1:0] order_t;

  localparam way_t STREAM_WAY = '0;

  function automatic order_t reset_order();
    order_t o;
    for (int r = 0; r < NUM_WAYS; r++) o[r] = way_t'(r);
    return o;
  endfunction
endpackage

// File: rtl/lru_rst_sync.sv
module lru_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_q_n = sync_q[1];
endmodule

// File: rtl/lru_order_store.sv
module lru_order_store
  import lru_pkg::*;
#(
  parameter int NUM_SETS = 128,
  localparam int IDX_W   = $clog2(NUM_SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] set_idx,
  input  logic             wr_en,
  input  order_t           wr_order,
  output order_t           rd_order
);
  order_t order_q [NUM_SETS];

  assign rd_order = order_q[set_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < NUM_SETS; s++) order_q[s] <= reset_order();
    end else if (wr_en) begin
      order_q[set_idx] <= wr_order;
    end
  end
endmodule

// File: rtl/lru_lock_store.sv
module lru_lock_store
  import lru_pkg::*;
#(
  parameter int NUM_SETS = 128,
  localparam int IDX_W   = $clog2(NUM_SETS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [IDX_W-1:0]    set_idx,
  input  logic                lock_req,
  input  logic                unlock_req,
  input  way_t                lock_way,
  output logic [NUM_WAYS-1:0] rd_lock,
  output logic                lock_ok
);
  logic [NUM_WAYS-1:0] lock_q [NUM_SETS];
  logic [NUM_WAYS-1:0] way_sel;
  logic [NUM_WAYS-1:0] lock_nxt;
  logic                would_fill;
  logic                lock_wr;

  assign rd_lock = lock_q[set_idx];

  // next-state
  always_comb begin
    way_sel    = '0;
    way_sel[lock_way] = 1'b1;
    would_fill = &(rd_lock | way_sel);
    lock_wr    = unlock_req | (lock_req & ~would_fill);
    lock_ok    = lock_wr;
    if (unlock_req) lock_nxt = rd_lock & ~way_sel;
    else            lock_nxt = rd_lock | way_sel;
  end

  // register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < NUM_SETS; s++) lock_q[s] <= '0;
    end else if (lock_wr) begin
      lock_q[set_idx] <= lock_nxt;
    end
  end
endmodule

// File: rtl/lru_victim_pick.sv
module lru_victim_pick
  import lru_pkg::*;
(
  input  order_t              order,
  input  logic [NUM_WAYS-1:0] valid,
  input  logic [NUM_WAYS-1:0] locked,
  input  logic                stream,
  output way_t                victim
);
  logic [NUM_WAYS-1:0] usable;

  genvar r;
  generate
    for (r = 0; r < NUM_WAYS; r++) begin : g_use
      assign usable[r] = ~valid[order[r]] | ~locked[order[r]];
    end
  endgenerate

  always_comb begin
    victim = order[0];
    for (int p = 1; p < NUM_WAYS; p++) begin
      if (usable[p]) victim = order[p];
    end
    if (stream) victim = STREAM_WAY;
  end
endmodule

// File: rtl/lru_promote.sv
module lru_promote
  import lru_pkg::*;
(
  input  order_t order_in,
  input  way_t   front_way,
  output order_t order_out
);
  logic [NUM_WAYS-1:0] at_rank;
  logic [NUM_WAYS-1:0] slide;

  genvar r;
  generate
    for (r = 0; r < NUM_WAYS; r++) begin : g_match
      assign at_rank[r] = (order_in[r] == front_way);
    end
  endgenerate

  always_comb begin
    for (int i = 0; i < NUM_WAYS; i++) begin
      slide[i] = 1'b0;
      for (int j = i; j < NUM_WAYS; j++) slide[i] = slide[i] | at_rank[j];
    end
  end

  assign order_out[0] = front_way;
  generate
    for (r = 1; r < NUM_WAYS; r++) begin : g_shift
      assign order_out[r] = slide[r] ? order_in[r-1] : order_in[r];
    end
  endgenerate
endmodule

// File: rtl/lru_victim_sel.sv
module lru_victim_sel
  import lru_pkg::*;
#(
  parameter int NUM_SETS = 128,
  localparam int IDX_W   = $clog2(NUM_SETS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [IDX_W-1:0]    set_idx,
  input  logic                hit,
  input  logic [WAY_W-1:0]    hit_way,
  input  logic                miss,
  input  logic                stream,
  input  logic [NUM_WAYS-1:0] way_valid,
  input  logic                lock_req,
  input  logic                unlock_req,
  input  logic [WAY_W-1:0]    lock_way,
  output logic [WAY_W-1:0]    victim_way,
  output logic                lock_ok
);
  logic                rst_q_n;
  order_t              ord_rd;
  order_t              ord_nxt;
  logic [NUM_WAYS-1:0] lock_rd;
  way_t                front_way;
  logic                ord_wr;

  lru_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  lru_order_store #(.NUM_SETS(NUM_SETS)) u_order (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .set_idx  (set_idx),
    .wr_en    (ord_wr),
    .wr_order (ord_nxt),
    .rd_order (ord_rd)
  );

  lru_lock_store #(.NUM_SETS(NUM_SETS)) u_lock (
    .clk        (clk),
    .rst_n      (rst_q_n),
    .set_idx    (set_idx),
    .lock_req   (lock_req),
    .unlock_req (unlock_req),
    .lock_way   (lock_way),
    .rd_lock    (lock_rd),
    .lock_ok    (lock_ok)
  );

  lru_victim_pick u_pick (
    .order  (ord_rd),
    .valid  (way_valid),
    .locked (lock_rd),
    .stream (stream),
    .victim (victim_way)
  );

  // hit outranks miss
  always_comb begin
    ord_wr    = hit | miss;
    front_way = hit ? hit_way : victim_way;
  end

  lru_promote u_promote (
    .order_in  (ord_rd),
    .front_way (front_way),
    .order_out (ord_nxt)
  );
endmodule

// File: rtl/lru_victim_sel_chk.sv
module lru_victim_sel_chk
  import lru_pkg::*;
#(
  parameter int NUM_SETS = 128,
  localparam int IDX_W   = $clog2(NUM_SETS)
) (
  input logic                clk,
  input logic                rst_q_n,
  input logic [IDX_W-1:0]    set_idx,
  input logic                hit,
  input logic [WAY_W-1:0]    hit_way,
  input logic                miss,
  input logic                stream,
  input logic [NUM_WAYS-1:0] way_valid,
  input logic                lock_req,
  input logic                unlock_req,
  input logic [WAY_W-1:0]    lock_way,
  input logic [WAY_W-1:0]    victim_way,
  input logic                lock_ok,
  input order_t              ord_rd,
  input logic [NUM_WAYS-1:0] lock_rd
);
  logic [NUM_WAYS-1:0] seen_ways;
  logic [NUM_WAYS-1:0] tgt_sel;

  always_comb begin
    seen_ways = '0;
    for (int r = 0; r < NUM_WAYS; r++) seen_ways[ord_rd[r]] = 1'b1;
    tgt_sel = '0;
    tgt_sel[lock_way] = 1'b1;
  end

  assert_stream_way0_R2: assert property (@(posedge clk) disable iff (!rst_q_n)
    stream |-> victim_way == STREAM_WAY);

  assert_victim_usable_R3: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!stream && victim_way != ord_rd[0]) |-> (!way_valid[victim_way] || !lock_rd[victim_way]));

  assert_mru_fallback_R4: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!stream && victim_way == ord_rd[0]) |->
      (way_valid[ord_rd[1]] && lock_rd[ord_rd[1]] && way_valid[ord_rd[2]] && lock_rd[ord_rd[2]]
       && way_valid[ord_rd[3]] && lock_rd[ord_rd[3]]));

  assert_order_perm_R5: assert property (@(posedge clk) disable iff (!rst_q_n)
    $countones(seen_ways) == NUM_WAYS);

  assert_hit_front_R5: assert property (@(posedge clk) disable iff (!rst_q_n)
    ($past(hit) && set_idx == $past(set_idx)) |-> ord_rd[0] == $past(hit_way));

  assert_fill_front_R6: assert property (@(posedge clk) disable iff (!rst_q_n)
    ($past(miss && !hit) && set_idx == $past(set_idx)) |-> ord_rd[0] == $past(victim_way));

  assert_never_full_R8: assert property (@(posedge clk) disable iff (!rst_q_n)
    !(&lock_rd));

  assert_lock_refused_R8: assert property (@(posedge clk) disable iff (!rst_q_n)
    (lock_req && !unlock_req && &(lock_rd | tgt_sel)) |-> !lock_ok);

  assert_unlock_ok_R9: assert property (@(posedge clk) disable iff (!rst_q_n)
    unlock_req |-> lock_ok);

  assert_unlock_clears_R9: assert property (@(posedge clk) disable iff (!rst_q_n)
    ($past(unlock_req) && set_idx == $past(set_idx)) |-> !lock_rd[$past(lock_way)]);
endmodule

bind lru_victim_sel lru_victim_sel_chk #(.NUM_SETS(NUM_SETS)) u_chk (
  .clk        (clk),
  .rst_q_n    (rst_q_n),
  .set_idx    (set_idx),
  .hit        (hit),
  .hit_way    (hit_way),
  .miss       (miss),
  .stream     (stream),
  .way_valid  (way_valid),
  .lock_req   (lock_req),
  .unlock_req (unlock_req),
  .lock_way   (lock_way),
  .victim_way (victim_way),
  .lock_ok    (lock_ok),
  .ord_rd     (ord_rd),
  .lock_rd    (lock_rd)
);

// File: tb/test_lru_victim_sel.sv
`timescale 1ns/1ps
module test_lru_victim_sel;
  localparam int SETS = 128;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] set_idx = '0;
  logic       hit = 1'b0;
  logic [1:0] hit_way = '0;
  logic       miss = 1'b0;
  logic       stream = 1'b0;
  logic [3:0] way_valid = 4'hF;
  logic       lock_req = 1'b0;
  logic       unlock_req = 1'b0;
  logic [1:0] lock_way = '0;
  logic [1:0] victim_way;
  logic       lock_ok;

  int n_checks = 0;
  int n_errors = 0;

  int  m_ord [SETS][4];
  bit  m_lck [SETS][4];

  always #2.5 clk = ~clk;

  lru_victim_sel #(.NUM_SETS(SETS)) i_lru_victim_sel (
    .clk(clk), .rst_n(rst_n), .set_idx(set_idx), .hit(hit), .hit_way(hit_way),
    .miss(miss), .stream(stream), .way_valid(way_valid), .lock_req(lock_req),
    .unlock_req(unlock_req), .lock_way(lock_way), .victim_way(victim_way),
    .lock_ok(lock_ok)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d (time %0t)", tag, act, exp, $time);
    end
  endtask

  function automatic int exp_victim(int s, bit [3:0] v, bit st);
    if (st) return 0;
    for (int p = 3; p >= 1; p--) begin
      int w = m_ord[s][p];
      if (!v[w] || !m_lck[s][w]) return w;
    end
    return m_ord[s][0];
  endfunction

  function automatic bit exp_ok(int s, bit lr, bit ur, int lw);
    int cnt = 0;
    if (ur) return 1'b1;
    if (!lr) return 1'b0;
    for (int w = 0; w < 4; w++) if (m_lck[s][w] || w == lw) cnt++;
    return cnt < 4;
  endfunction

  function automatic void promote(int s, int w);
    int p = 0;
    for (int i = 0; i < 4; i++) if (m_ord[s][i] == w) p = i;
    for (int i = p; i > 0; i--) m_ord[s][i] = m_ord[s][i-1];
    m_ord[s][0] = w;
  endfunction

  task automatic step(input int s, input bit h, input int hw, input bit m, input bit st,
                      input bit [3:0] v, input bit lr, input bit ur, input int lw,
                      input string tag);
    int ev;
    bit eok;
    string vt;
    @(negedge clk);
    set_idx = 7'(s); hit = h; hit_way = 2'(hw); miss = m; stream = st;
    way_valid = v; lock_req = lr; unlock_req = ur; lock_way = 2'(lw);
    #1;
    ev  = exp_victim(s, v, st);
    eok = exp_ok(s, lr, ur, lw);
    vt  = tag;
    if (vt == "") vt = st ? "R2" : ((ev == m_ord[s][0]) ? "R4" : "R3");
    check(victim_way == 2'(ev), vt, int'(victim_way), ev);
    if (lr || ur) check(lock_ok == eok, ur ? "R9" : "R8", int'(lock_ok), int'(eok));
    @(posedge clk);
    if (ur) m_lck[s][lw] = 1'b0;
    else if (lr && eok) m_lck[s][lw] = 1'b1;
    if (h) promote(s, hw);
    else if (m) promote(s, ev);
  endtask

  task automatic idle(input int s, input bit [3:0] v, input string tag);
    step(s, 0, 0, 0, 0, v, 0, 0, 0, tag);
  endtask

  initial begin
    #(200000 * 5);
    n_errors++;
    n_checks++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    for (int s = 0; s < SETS; s++)
      for (int i = 0; i < 4; i++) begin m_ord[s][i] = i; m_lck[s][i] = 1'b0; end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1: reset ranking, all sets
    for (int s = 0; s < SETS; s++) idle(s, 4'hF, "R1");

    // R2: streaming over all valid patterns and lock states
    step(3, 0, 0, 0, 0, 4'hF, 1, 0, 0, "R8");
    step(3, 0, 0, 0, 0, 4'hF, 1, 0, 3, "R8");
    for (int v = 0; v < 16; v++) idle(3, 4'(v), "");
    for (int v = 0; v < 16; v++) step(3, 0, 0, 0, 1, 4'(v), 0, 0, 0, "R2");

    // R5: hits on rear and middle ways
    step(20, 1, 3, 0, 0, 4'hF, 0, 0, 0, "R5");
    idle(20, 4'hF, "R5");
    step(20, 1, 1, 0, 0, 4'hF, 0, 0, 0, "R5");
    idle(20, 4'hF, "R5");
    step(20, 1, 2, 0, 0, 4'hF, 0, 0, 0, "R5");
    idle(20, 4'hF, "R5");
    step(20, 1, 2, 0, 0, 4'hF, 0, 0, 0, "R5");
    idle(20, 4'hF, "R5");

    // R6: refill promotes victim, normal and streaming
    step(21, 0, 0, 1, 0, 4'hF, 0, 0, 0, "R6");
    idle(21, 4'hF, "R6");
    step(22, 0, 0, 1, 1, 4'hF, 0, 0, 0, "R6");
    idle(22, 4'hF, "R6");

    // R7: hit and miss together
    step(23, 1, 1, 1, 0, 4'hF, 0, 0, 0, "R7");
    idle(23, 4'hF, "R7");

    // R10: neighbouring sets untouched
    idle(24, 4'hF, "R10");
    idle(19, 4'hF, "R10");

    // R8 / R4: fill the lock set up to three ways, refuse the fourth
    step(30, 0, 0, 0, 0, 4'hF, 1, 0, 0, "R8");
    step(30, 0, 0, 0, 0, 4'hF, 1, 0, 1, "R8");
    step(30, 0, 0, 0, 0, 4'hF, 1, 0, 2, "R8");
    step(30, 0, 0, 0, 0, 4'hF, 1, 0, 3, "R8");
    idle(30, 4'hF, "R8");
    step(30, 1, 3, 0, 0, 4'hF, 0, 0, 0, "R5");
    idle(30, 4'hF, "R4");
    step(30, 0, 0, 1, 0, 4'hF, 0, 0, 0, "R4");
    idle(30, 4'b1110, "R3");
    idle(30, 4'b1011, "R3");

    // R9: unlock wins over a simultaneous lock
    step(30, 0, 0, 0, 0, 4'hF, 1, 1, 0, "R9");
    idle(30, 4'hF, "R9");
    step(30, 0, 0, 0, 0, 4'hF, 1, 0, 0, "R8");
    step(30, 0, 0, 0, 0, 4'hF, 0, 1, 3, "R9");
    step(30, 0, 0, 0, 0, 4'hF, 0, 1, 3, "R9");
    idle(30, 4'hF, "R9");

    // mixed pseudo-random run on a few sets
    for (int k = 0; k < 4000; k++) begin
      int s, r;
      r = $urandom;
      case (r % 4)
        0: s = 0;
        1: s = 1;
        2: s = 2;
        default: s = 127;
      endcase
      r = $urandom;
      step(s, r[0], r[2:1], r[3], (r[7:4] == 0), r[11:8] | {3'b000, r[12]},
           (r[15:13] < 3), (r[18:16] == 0), r[20:19], "");
    end

    @(negedge clk);
    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule